// File: doc/BRIEF.md
# Three-Channel Reloading Down-Counter Timer with Capture

This block holds three independent 32-bit countdown channels. Each channel decrements on ticks from a source chosen in its control word: one of five taps of a shared power-of-four divider of the system clock, a real-time tick input, or either edge of an external clock pin. When a tick arrives while a channel holds zero, the channel loads its stored reload value and flags an underflow. The channel can raise an interrupt from that flag.

The last channel can also snapshot its running count when a chosen edge appears on a capture pin. Each snapshot sets a capture flag, which can drive its own interrupt. It also raises a transfer request toward a DMA engine, and that request stays up until the engine acknowledges it. Software reaches every register through a single-cycle word-addressed write port and a combinational read port.

Top module: `tri_timer`

## Requirements
- R1: After reset every count and reload register reads 0xFFFFFFFF, every control word reads 0, the capture register reads 0, and all interrupt and request outputs are low.
- R2: The address is split into a channel index and a register index: address = channel*4 + register. Register 0 is reload, 1 is count and 2 is control. Address 12 reads the capture register. Reload and count can be written at any time. Writing reload while a channel runs does not alter its count.
- R3: A tick that arrives while the count is 0 loads the reload value and sets the underflow flag (control bit 6) on the same clock edge. Any other tick decrements the count by one.
- R4: Source codes in control bits 2:0 select the system clock divided by 4, 16, 64, 256 and 1024 for codes 0 to 4. Code 5 selects the real-time tick input, code 6 selects the external clock pin, and code 7 selects nothing. Divided sources give exactly one tick per divisor cycles.
- R5: A channel whose start bit (control bit 4) is 0 holds its count regardless of ticks.
- R6: The external clock and capture pins pass through two synchronizing flops before edge detection. Control bit 3 chooses the active edge: 0 for rising, 1 for falling.
- R7: The underflow flag (bit 6) and the capture flag (bit 8) are sticky. Writing 0 to a flag clears it and writing 1 leaves it unchanged. A new event in the same cycle as a clearing write leaves the flag set.
- R8: Each channel's underflow interrupt equals its underflow flag ANDed with underflow enable bit 5. The capture interrupt equals the capture flag ANDed with bit 7 of channel 2.
- R9: With capture enable (channel 2 control bit 9) set, each active capture edge copies channel 2's count into the capture register, sets the capture flag and raises the DMA request. Edges of the other polarity do nothing.
- R10: The DMA request stays high until a one-cycle acknowledge arrives. A capture in the same cycle as the acknowledge keeps it high. A capture while the request is pending overwrites the capture register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word address (channel*4 + register, 12 = capture) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| ext_clk_in | input | 1 | External count clock, asynchronous |
| cap_in | input | 1 | Capture trigger pin, asynchronous |
| rtc_tick | input | 1 | Synchronous real-time tick enable |
| dma_ack | input | 1 | One-cycle DMA acknowledge |
| uf_irq | output | 3 | Per-channel underflow interrupts |
| cap_irq | output | 1 | Capture interrupt of channel 2 |
| dma_req | output | 1 | DMA transfer request of channel 2 |

## Verification
Two pairs of functions can land in the same clock edge. A software flag clear can coincide with an underflow, and a DMA acknowledge can coincide with a fresh capture. The bench provokes the first by raising the real-time tick on the same cycle as a control write that clears the underflow flag, with the count at zero. The flag must read set afterwards and the count must equal the reload value. For the second, the bench times the acknowledge against the two-flop synchronizer delay so that it lands on the capture edge, and then requires the request to remain high.

// File: rtl/tri_timer_pkg.sv
package tri_timer_pkg;

    localparam int NUM_CH = 3;
    localparam int CNT_W  = 32;
    localparam int CAP_CH = 2;
    localparam int TAPS   = 5;
    localparam int DIV_W  = 2 * TAPS;
    localparam int CH_W   = $clog2(NUM_CH + 1);
    localparam int ADDR_W = CH_W + 2;
    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        SRC_DIV4    = 3'd0,
        SRC_DIV16   = 3'd1,
        SRC_DIV64   = 3'd2,
        SRC_DIV256  = 3'd3,
        SRC_DIV1024 = 3'd4,
        SRC_RTC     = 3'd5,
        SRC_EXT     = 3'd6,
        SRC_OFF     = 3'd7
    } src_sel_e;

    typedef enum logic [1:0] {
        REG_RELOAD = 2'd0,
        REG_COUNT  = 2'd1,
        REG_CTRL   = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;

    // packed MSB first: bit 9 down to bit 0
    typedef struct packed {
        logic     cap_en;
        logic     cap_flag;
        logic     cap_ie;
        logic     uf_flag;
        logic     uf_ie;
        logic     start;
        logic     fall_edge;
        src_sel_e src;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic [TAPS-1:0] presc;
        logic            rtc;
        logic            ext_rise;
        logic            ext_fall;
        logic            cap_rise;
        logic            cap_fall;
    } tick_bus_t;

    function automatic logic pick_tick(src_sel_e s, logic fall, tick_bus_t t);
        logic r;
        case (s)
            SRC_RTC:     r = t.rtc;
            SRC_EXT:     r = fall ? t.ext_fall : t.ext_rise;
            SRC_OFF:     r = 1'b0;
            SRC_DIV4:    r = t.presc[0];
            SRC_DIV16:   r = t.presc[1];
            SRC_DIV64:   r = t.presc[2];
            SRC_DIV256:  r = t.presc[3];
            default:     r = t.presc[4];
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler
    import tri_timer_pkg::*;
#(
    parameter int N_TAPS = TAPS
) (
    input  logic              clk,
    input  logic              rst,
    output logic [N_TAPS-1:0] tap
);

    localparam int W = 2 * N_TAPS;

    logic [W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + 1'b1;
    end

    // tap g pulses once per 4^(g+1) cycles
    generate
        for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
            assign tap[g] = &div_q[2*g+1:0];
        end
    endgenerate

    AST_TAP_PULSE: assert property (@(posedge clk) disable iff (rst)
        tap[0] |=> !tap[0]);                                         // R4

endmodule

// File: rtl/tt_sync_edge.sv
module tt_sync_edge (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise,
    output logic fall
);

    // [0],[1] synchronizer, [2] previous synchronized value
    logic [2:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) sr_q <= '0;
        else     sr_q <= {sr_q[1:0], din};
    end

    assign rise = sr_q[1] & ~sr_q[2];
    assign fall = ~sr_q[1] & sr_q[2];

    AST_RISE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);                                             // R6

endmodule

// File: rtl/tt_channel.sv
module tt_channel
    import tri_timer_pkg::*;
#(
    parameter int W       = CNT_W,
    parameter bit HAS_CAP = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_reload,
    input  logic      wr_count,
    input  logic      wr_ctrl,
    input  logic [W-1:0] wdata,
    input  tick_bus_t ticks,
    input  logic      dma_ack,
    output logic [W-1:0] count,
    output logic [W-1:0] reload,
    output logic [W-1:0] cap_val,
    output ctrl_t     ctrl,
    output logic      uf_irq,
    output logic      cap_irq,
    output logic      dma_req
);

    ctrl_t wv;
    logic  tick;
    logic  underflow;
    logic  cap_evt;

    assign wv        = ctrl_t'(wdata[CTRL_W-1:0]);
    assign tick      = ctrl.start && pick_tick(ctrl.src, ctrl.fall_edge, ticks);
    assign underflow = tick && (count == '0) && !wr_count;

    always_ff @(posedge clk) begin
        if (rst)            count <= '1;
        else if (wr_count)  count <= wdata;
        else if (underflow) count <= reload;
        else if (tick)      count <= count - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)            reload <= '1;
        else if (wr_reload) reload <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl.src       <= wv.src;
                ctrl.fall_edge <= wv.fall_edge;
                ctrl.start     <= wv.start;
                ctrl.uf_ie     <= wv.uf_ie;
                if (!wv.uf_flag) ctrl.uf_flag <= 1'b0;
                if (HAS_CAP) begin
                    ctrl.cap_en <= wv.cap_en;
                    ctrl.cap_ie <= wv.cap_ie;
                    if (!wv.cap_flag) ctrl.cap_flag <= 1'b0;
                end
            end
            if (underflow) ctrl.uf_flag  <= 1'b1;
            if (cap_evt)   ctrl.cap_flag <= 1'b1;
        end
    end

    assign uf_irq  = ctrl.uf_flag & ctrl.uf_ie;
    assign cap_irq = ctrl.cap_flag & ctrl.cap_ie;

    generate
        if (HAS_CAP) begin : g_cap
            logic [W-1:0] cap_q;
            logic         req_q;

            assign cap_evt = ctrl.cap_en &&
                             (ctrl.fall_edge ? ticks.cap_fall : ticks.cap_rise);

            always_ff @(posedge clk) begin
                if (rst)          cap_q <= '0;
                else if (cap_evt) cap_q <= count;
            end

            always_ff @(posedge clk) begin
                if (rst)          req_q <= 1'b0;
                else if (cap_evt) req_q <= 1'b1;
                else if (dma_ack) req_q <= 1'b0;
            end

            assign cap_val = cap_q;
            assign dma_req = req_q;

            AST_DMA_HOLD: assert property (@(posedge clk) disable iff (rst)
                (dma_req && !dma_ack) |=> dma_req);                  // R10

            AST_CAP_LATCH: assert property (@(posedge clk) disable iff (rst)
                cap_evt |=> (cap_val == $past(count) && dma_req));   // R9
        end else begin : g_nocap
            assign cap_evt = 1'b0;
            assign cap_val = '0;
            assign dma_req = 1'b0;
        end
    endgenerate

    AST_UF_RELOAD: assert property (@(posedge clk) disable iff (rst)
        underflow |=> (count == $past(reload) && ctrl.uf_flag));     // R3

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.start && !wr_count) |=> $stable(count));              // R5

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ctrl.uf_flag && !wr_ctrl) |=> ctrl.uf_flag);                // R7

endmodule

// File: rtl/tri_timer.sv
module tri_timer
    import tri_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_clk_in,
    input  logic              cap_in,
    input  logic              rtc_tick,
    input  logic              dma_ack,
    output logic [NUM_CH-1:0] uf_irq,
    output logic              cap_irq,
    output logic              dma_req
);

    logic [TAPS-1:0] taps;
    logic            ext_rise, ext_fall, cap_rise, cap_fall;
    tick_bus_t       tbus;

    logic [CH_W-1:0] ch_idx;
    reg_sel_e        sub;

    logic [CNT_W-1:0] cnt_a  [NUM_CH];
    logic [CNT_W-1:0] rel_a  [NUM_CH];
    logic [CNT_W-1:0] capv_a [NUM_CH];
    ctrl_t            ctrl_a [NUM_CH];
    logic [NUM_CH-1:0] capirq_a;
    logic [NUM_CH-1:0] req_a;

    tt_prescaler #(.N_TAPS(TAPS)) u_presc (
        .clk (clk),
        .rst (rst),
        .tap (taps)
    );

    tt_sync_edge u_ext_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (ext_clk_in),
        .rise (ext_rise),
        .fall (ext_fall)
    );

    tt_sync_edge u_cap_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (cap_in),
        .rise (cap_rise),
        .fall (cap_fall)
    );

    assign tbus = '{presc: taps, rtc: rtc_tick, ext_rise: ext_rise,
                    ext_fall: ext_fall, cap_rise: cap_rise, cap_fall: cap_fall};

    assign ch_idx = bus_addr[ADDR_W-1:2];
    assign sub    = reg_sel_e'(bus_addr[1:0]);

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            logic sel;
            assign sel = bus_wr && (ch_idx == CH_W'(g));

            tt_channel #(
                .W       (CNT_W),
                .HAS_CAP (g == CAP_CH)
            ) u_ch (
                .clk       (clk),
                .rst       (rst),
                .wr_reload (sel && sub == REG_RELOAD),
                .wr_count  (sel && sub == REG_COUNT),
                .wr_ctrl   (sel && sub == REG_CTRL),
                .wdata     (bus_wdata),
                .ticks     (tbus),
                .dma_ack   (dma_ack),
                .count     (cnt_a[g]),
                .reload    (rel_a[g]),
                .cap_val   (capv_a[g]),
                .ctrl      (ctrl_a[g]),
                .uf_irq    (uf_irq[g]),
                .cap_irq   (capirq_a[g]),
                .dma_req   (req_a[g])
            );
        end
    endgenerate

    assign cap_irq = capirq_a[CAP_CH];
    assign dma_req = req_a[CAP_CH];

    always_comb begin
        bus_rdata = '0;
        if (int'(ch_idx) < NUM_CH) begin
            case (sub)
                REG_RELOAD: bus_rdata = rel_a[ch_idx];
                REG_COUNT:  bus_rdata = cnt_a[ch_idx];
                REG_CTRL:   bus_rdata = DATA_W'(ctrl_a[ch_idx]);
                default:    bus_rdata = '0;
            endcase
        end else if (sub == REG_RELOAD) begin
            bus_rdata = capv_a[CAP_CH];
        end
    end

    AST_IRQ_LOW_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        !ctrl_a[0].uf_flag |-> !uf_irq[0]);                          // R8

endmodule

// File: tb/tri_timer_bench.sv
`timescale 1ns/1ps
module tri_timer_bench;
    import tri_timer_pkg::*;

    localparam realtime CLK_P = 10ns;
    localparam logic [3:0] A_CAP = 4'd12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ext_clk_in = 1'b0;
    logic        cap_in = 1'b0;
    logic        rtc_tick = 1'b0;
    logic        dma_ack = 1'b0;
    logic [2:0]  uf_irq;
    logic        cap_irq;
    logic        dma_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    tri_timer u_tri_timer (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .ext_clk_in (ext_clk_in),
        .cap_in     (cap_in),
        .rtc_tick   (rtc_tick),
        .dma_ack    (dma_ack),
        .uf_irq     (uf_irq),
        .cap_irq    (cap_irq),
        .dma_req    (dma_req)
    );

    function automatic logic [3:0] ad(int ch, int r);
        return 4'(ch * 4 + r);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse_rtc();
        @(negedge clk); rtc_tick = 1'b1;
        @(negedge clk); rtc_tick = 1'b0;
    endtask

    task automatic set_ext(logic v);
        @(negedge clk); ext_clk_in = v;
        repeat (5) @(negedge clk);
    endtask

    task automatic set_cap(logic v);
        @(negedge clk); cap_in = v;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int c = 0; c < 3; c++) begin
            rd(ad(c, 0), d); check("R1 reload reset", d, 32'hFFFF_FFFF);
            rd(ad(c, 1), d); check("R1 count reset", d, 32'hFFFF_FFFF);
            rd(ad(c, 2), d); check("R1 ctrl reset", d, 32'h0);
        end
        rd(A_CAP, d); check("R1 capture reset", d, 32'h0);
        check("R1 irq/req reset", {27'b0, uf_irq, cap_irq, dma_req}, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(ad(1, 2), 32'h15);           // ch1 running on rtc, no ticks
        wr(ad(1, 1), 32'h0000_0400);
        wr(ad(1, 0), 32'h0000_0007);
        rd(ad(1, 0), d); check("R2 reload written while running", d, 32'h7);
        rd(ad(1, 1), d); check("R2 count untouched by reload write", d, 32'h400);
    endtask

    task automatic t_prescale();
        logic [31:0] a, b;
        wr(ad(0, 1), 32'd100000);
        wr(ad(0, 2), 32'h10);           // start, /4
        @(negedge clk); rd(ad(0, 1), a);
        repeat (64) @(negedge clk); rd(ad(0, 1), b);
        check("R4 div4 rate", a - b, 32'd16);
        wr(ad(0, 2), 32'h11);           // /16
        @(negedge clk); rd(ad(0, 1), a);
        repeat (256) @(negedge clk); rd(ad(0, 1), b);
        check("R4 div16 rate", a - b, 32'd16);
        wr(ad(0, 2), 32'h14);           // /1024
        @(negedge clk); rd(ad(0, 1), a);
        repeat (2048) @(negedge clk); rd(ad(0, 1), b);
        check("R4 div1024 rate", a - b, 32'd2);
        wr(ad(0, 2), 32'h17);           // code 7: no source
        @(negedge clk); rd(ad(0, 1), a);
        repeat (300) @(negedge clk); rd(ad(0, 1), b);
        check("R4 code 7 silent", b, a);
    endtask

    task automatic t_stop();
        logic [31:0] a, b;
        wr(ad(0, 2), 32'h00);           // stopped, /4
        rd(ad(0, 1), a);
        repeat (100) @(negedge clk); rd(ad(0, 1), b);
        check("R5 stopped holds", b, a);
        wr(ad(0, 2), 32'h05);           // stopped, rtc
        pulse_rtc();
        rd(ad(0, 1), b);
        check("R5 stopped ignores rtc tick", b, a);
    endtask

    task automatic t_underflow();
        logic [31:0] d;
        wr(ad(0, 0), 32'd3);
        wr(ad(0, 1), 32'd1);
        wr(ad(0, 2), 32'h15);           // start, rtc, uf_ie=0
        pulse_rtc();
        rd(ad(0, 1), d); check("R3 decrement", d, 32'd0);
        rd(ad(0, 2), d); check("R3 no flag before underflow", d[6], 1'b0);
        pulse_rtc();
        rd(ad(0, 1), d); check("R3 reload on underflow", d, 32'd3);
        rd(ad(0, 2), d); check("R3 flag on underflow", d[6], 1'b1);
        check("R8 irq masked", uf_irq[0], 1'b0);
        wr(ad(0, 2), 32'h75);           // enable, write 1 keeps flag
        check("R8 irq enabled", uf_irq[0], 1'b1);
        check("R7 write 1 keeps flag", uf_irq[0], 1'b1);
        // clear and underflow on the same edge
        wr(ad(0, 1), 32'd0);
        @(negedge clk);
        rtc_tick = 1'b1; bus_wr = 1'b1; bus_addr = ad(0, 2); bus_wdata = 32'h35;
        @(negedge clk);
        rtc_tick = 1'b0; bus_wr = 1'b0;
        rd(ad(0, 2), d); check("R7 event beats clear", d[6], 1'b1);
        rd(ad(0, 1), d); check("R3 reload during clear", d, 32'd3);
        wr(ad(0, 2), 32'h35);
        rd(ad(0, 2), d); check("R7 write 0 clears", d[6], 1'b0);
        check("R8 irq follows flag", uf_irq[0], 1'b0);
        wr(ad(0, 2), 32'h75);
        rd(ad(0, 2), d); check("R7 write 1 does not set", d[6], 1'b0);
        wr(ad(0, 2), 32'h00);
    endtask

    task automatic t_ext();
        logic [31:0] d;
        wr(ad(1, 1), 32'd100);
        wr(ad(1, 2), 32'h16);           // start, ext, rising
        set_ext(1'b1);
        rd(ad(1, 1), d); check("R6 rising edge counts", d, 32'd99);
        set_ext(1'b0);
        rd(ad(1, 1), d); check("R6 falling ignored in rising mode", d, 32'd99);
        wr(ad(1, 2), 32'h1E);           // falling
        wr(ad(1, 1), 32'd100);
        set_ext(1'b1);
        rd(ad(1, 1), d); check("R6 rising ignored in falling mode", d, 32'd100);
        set_ext(1'b0);
        rd(ad(1, 1), d); check("R6 falling edge counts", d, 32'd99);
        wr(ad(1, 2), 32'h00);
    endtask

    task automatic t_capture();
        logic [31:0] d;
        wr(ad(2, 1), 32'h1234);
        wr(ad(2, 2), 32'h285);          // cap_en, cap_ie, rtc, stopped, rising
        set_cap(1'b1);
        rd(A_CAP, d); check("R9 capture value", d, 32'h1234);
        rd(ad(2, 2), d); check("R9 capture flag", d[8], 1'b1);
        check("R8 capture irq", cap_irq, 1'b1);
        check("R9 dma request", dma_req, 1'b1);
        wr(ad(2, 1), 32'h55);
        set_cap(1'b0);
        rd(A_CAP, d); check("R9 falling ignored in rising mode", d, 32'h1234);
        set_cap(1'b1);
        rd(A_CAP, d); check("R10 overwrite while pending", d, 32'h55);
        check("R10 request still pending", dma_req, 1'b1);
        @(negedge clk); dma_ack = 1'b1;
        @(negedge clk); dma_ack = 1'b0;
        check("R10 ack drops request", dma_req, 1'b0);
        set_cap(1'b0);
        check("R9 no request on wrong edge", dma_req, 1'b0);
        // capture on the same edge as an acknowledge
        set_cap(1'b1);
        check("R10 pending before overlap", dma_req, 1'b1);
        set_cap(1'b0);
        @(negedge clk); cap_in = 1'b1;
        @(negedge clk);
        @(negedge clk); dma_ack = 1'b1;
        @(negedge clk); dma_ack = 1'b0;
        check("R10 capture beats ack", dma_req, 1'b1);
        @(negedge clk); dma_ack = 1'b1;
        @(negedge clk); dma_ack = 1'b0;
        check("R10 ack alone clears", dma_req, 1'b0);
        // falling-edge capture
        wr(ad(2, 2), 32'h28D);          // falling, clears capture flag
        check("R7 capture flag cleared", cap_irq, 1'b0);
        wr(ad(2, 1), 32'h77);
        set_cap(1'b0);
        rd(A_CAP, d); check("R9 falling capture", d, 32'h77);
        wr(ad(2, 1), 32'h88);
        set_cap(1'b1);
        rd(A_CAP, d); check("R9 rising ignored in falling mode", d, 32'h77);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_prescale();
        t_stop();
        t_underflow();
        t_ext();
        t_capture();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule